// File: doc/BRIEF.md
# DMA Address, Count and Page-Check Registers

This block holds the processor-programmed state of a disk DMA engine: a transfer counter, an enable flag, a direction flag and a word-aligned memory address. It also checks the target page of every transfer. The processor loads the counter with one 16-bit write. The address is loaded in two halves. The half that a write updates, and the new bits themselves, are taken from the processor address lines; the data bus plays no part in an address write.

For each transfer request, the block looks up the two page bits of the page that holds the current address. If the page is mapped, the block grants the transfer, writes back updated page bits in the same cycle, steps the address forward by one word and decrements the counter. If the page is unmapped, the block refuses the transfer. It loads three coded status words and raises a level-7 interrupt request, then refuses all further transfers until software writes the counter again.

Top module: `dma_page_ctl`

## Requirements
- R1: Reset state: counter 0, enable 0, direction 0, address 0, `gen_stat`, `bsr0` and `bsr1` all 0xFFFF, `irq7` low, and no ack, fault or page write.
- R2: A write with `reg_sel`=0 loads the counter with (`wr_data[13:0]` + 1) modulo 2^14, the direction flag from `wr_data[14]` (1 = DMA reads memory) and enable from `wr_data[15]`. A data value of 0x3FFF therefore leaves a counter of 0.
- R3: `rd_count` always shows the 14-bit counter in bits 13:0, with bits 15 and 14 read as 1.
- R4: A write with `reg_sel`=1 and `cpu_addr[14]`=1 loads address bits 21:9 from `cpu_addr[13:1]` and leaves address bits 8:1 unchanged.
- R5: A write with `reg_sel`=1 and `cpu_addr[14]`=0 loads address bits 8:1 from `cpu_addr[8:1]` and leaves bits 21:9 unchanged, whatever `cpu_addr[13:9]` holds.
- R6: A write with `reg_sel`=2 sets the direction flag from `wr_data[14]` and changes nothing else.
- R7: A request is granted only when enable is 1, the counter is nonzero, no fault is pending and `reg_wr` is low. Any other request leaves all outputs and state unchanged.
- R8: A granted request whose page bits are 00 (bit 1 = referenced, bit 0 = valid/dirty) pulses `xfer_fault` one cycle later. It sets `gen_stat` to 0xABFF, ORed with 0x4000 if the direction is read and with 0x0400 if `par_irq_en` is 1. It sets `bsr0` to 0x3C00 ORed with address bits 23:16, sets `bsr1` to address bits 15:0, raises `irq7`, and leaves the counter and the address unchanged.
- R9: A granted request on a page with nonzero bits drives `page_wr_en` in the same cycle with new bits {1, b0'}. Here b0' is 1 when the old bits are 11, or when they are 01 or 10 and the direction is write. One cycle later the block pulses `xfer_ack`, advances the address by 2 and decrements the counter.
- R10: After a fault, the block grants no request and holds its status words until a counter write. That write lowers `irq7` and re-arms the block.
- R11: When a register write and a request fall in the same cycle, the write takes effect and the request is not granted: there is no page write, no ack and no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | 0 counter, 1 address, 2 misc control, 3 none |
| cpu_addr | input | 14 | Processor address bits 14:1 |
| wr_data | input | 16 | Processor write data |
| rd_count | output | 16 | Counter readback |
| mem_addr | output | 22 | Current DMA byte address |
| xfer_req | input | 1 | Transfer request, held until answered |
| xfer_ack | output | 1 | Transfer completed (pulse) |
| xfer_fault | output | 1 | Transfer refused on unmapped page (pulse) |
| page_idx | output | 10 | Page index of current address |
| page_bits_in | input | 2 | Page bits of `page_idx` |
| page_wr_en | output | 1 | Page-bit write-back strobe |
| page_bits_out | output | 2 | Page bits to write back |
| par_irq_en | input | 1 | Parity interrupt enable, folded into fault status |
| gen_stat | output | 16 | General status word |
| bsr0 | output | 16 | Bus status word 0 |
| bsr1 | output | 16 | Bus status word 1 |
| irq7 | output | 1 | Level-7 interrupt request |

## Verification
A processor register write and a transfer request can fall in the same clock cycle. The bench provokes this by holding `xfer_req` high while it writes the misc-control register, and at other times while it writes the counter. A behavioural model that gives the write precedence is compared with the design on every clock. The comparison requires no page write-back and no ack in that cycle, a counter left exactly as the write set it, and a grant on the next cycle once the write has gone. The same comparison covers the fault path, where a blocked engine must ignore a request that is held high over several cycles.

// File: rtl/dmar_pkg.sv
package dmar_pkg;

  typedef enum logic [1:0] {
    SEL_COUNT = 2'd0,
    SEL_ADDR  = 2'd1,
    SEL_MISC  = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam logic [15:0] STAT_IDLE = 16'hFFFF;
  localparam logic [15:0] FLT_BASE  = 16'hABFF;
  localparam logic [15:0] FLT_READ  = 16'h4000;
  localparam logic [15:0] FLT_PIE   = 16'h0400;
  localparam logic [15:0] BSR0_BASE = 16'h3C00;

  // page bits: [1] referenced, [0] valid/dirty
  function automatic logic [1:0] page_update(input logic [1:0] old_b, input logic mem_wr);
    logic b0;
    b0 = (old_b == 2'b11) | (mem_wr & (old_b[1] ^ old_b[0]));
    return {1'b1, b0};
  endfunction

endpackage

// File: rtl/dmar_cfg.sv
module dmar_cfg
  import dmar_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int CNT_W  = 14,
  localparam int HI_W  = ADDR_W - 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  reg_sel_e          sel,
  input  logic [14:1]       cpu_addr,
  input  logic [15:0]       wr_data,
  input  logic              step,
  output logic [CNT_W-1:0]  count_q,
  output logic              en_q,
  output logic              rd_dir_q,
  output logic [ADDR_W-1:0] addr_q
);

  logic [CNT_W-1:0]  cnt_d;
  logic              en_d, dir_d, ld;
  logic [ADDR_W-1:0] addr_d;

  assign ld = wr_en | step;

  always_comb begin
    cnt_d  = count_q;
    en_d   = en_q;
    dir_d  = rd_dir_q;
    addr_d = addr_q;
    if (wr_en) begin
      unique case (sel)
        SEL_COUNT: begin
          cnt_d = wr_data[CNT_W-1:0] + CNT_W'(1);
          dir_d = wr_data[14];
          en_d  = wr_data[15];
        end
        SEL_ADDR: begin
          if (cpu_addr[14]) addr_d[ADDR_W-1:9] = cpu_addr[HI_W:1];
          else              addr_d[8:1]        = cpu_addr[8:1];
        end
        SEL_MISC: dir_d = wr_data[14];
        default: ;
      endcase
    end else if (step) begin
      cnt_d  = count_q - CNT_W'(1);
      addr_d = addr_q + ADDR_W'(2);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      en_q     <= 1'b0;
      rd_dir_q <= 1'b0;
      addr_q   <= '0;
    end else if (ld) begin
      count_q  <= cnt_d;
      en_q     <= en_d;
      rd_dir_q <= dir_d;
      addr_q   <= addr_d;
    end
  end

  a_r4_hi_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_ADDR && cpu_addr[14]) |=> $stable(addr_q[8:0]));

  a_r5_lo_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sel == SEL_ADDR && !cpu_addr[14]) |=> $stable(addr_q[ADDR_W-1:9]));

endmodule

// File: rtl/dmar_pgchk.sv
module dmar_pgchk
  import dmar_pkg::*;
(
  input  logic       grant,
  input  logic [1:0] pbits_in,
  input  logic       rd_dir,
  output logic       fault,
  output logic       pg_we,
  output logic [1:0] pbits_new
);

  logic unmapped;

  always_comb begin
    unmapped  = (pbits_in == 2'b00);
    fault     = grant & unmapped;
    pg_we     = grant & ~unmapped;
    pbits_new = page_update(pbits_in, ~rd_dir);
  end

endmodule

// File: rtl/dmar_fstat.sv
module dmar_fstat
  import dmar_pkg::*;
#(
  parameter int ADDR_W = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flt,
  input  logic              clr,
  input  logic              rd_dir,
  input  logic              pie,
  input  logic [ADDR_W-1:0] flt_addr,
  output logic [15:0]       gen_stat,
  output logic [15:0]       bsr0,
  output logic [15:0]       bsr1,
  output logic              irq_q
);

  logic [15:0] gs_d, b0_d, b1_d;
  logic        irq_d, irq_en;
  logic [7:0]  addr_hi8;

  assign addr_hi8 = 8'(flt_addr >> 16);
  assign irq_en   = flt | clr;

  always_comb begin
    gs_d  = FLT_BASE | (rd_dir ? FLT_READ : 16'h0) | (pie ? FLT_PIE : 16'h0);
    b0_d  = BSR0_BASE | {8'h00, addr_hi8};
    b1_d  = 16'(flt_addr);
    irq_d = flt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_stat <= STAT_IDLE;
      bsr0     <= STAT_IDLE;
      bsr1     <= STAT_IDLE;
    end else if (flt) begin
      gen_stat <= gs_d;
      bsr0     <= b0_d;
      bsr1     <= b1_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end

  a_r10_status_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !clr) |=> (irq_q && $stable(gen_stat) && $stable(bsr0) && $stable(bsr1)));

endmodule

// File: rtl/dma_page_ctl.sv
module dma_page_ctl
  import dmar_pkg::*;
#(
  parameter int ADDR_W     = 22,
  parameter int CNT_W      = 14,
  parameter int PAGE_SHIFT = 12,
  localparam int PG_W      = ADDR_W - PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [14:1]       cpu_addr,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_count,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              xfer_req,
  output logic              xfer_ack,
  output logic              xfer_fault,
  output logic [PG_W-1:0]   page_idx,
  input  logic [1:0]        page_bits_in,
  output logic              page_wr_en,
  output logic [1:0]        page_bits_out,
  input  logic              par_irq_en,
  output logic [15:0]       gen_stat,
  output logic [15:0]       bsr0,
  output logic [15:0]       bsr1,
  output logic              irq7
);

  reg_sel_e          sel;
  logic [CNT_W-1:0]  count_q;
  logic              en_q, rd_dir_q, grant, fault, step, cnt_clr;
  logic [ADDR_W-1:0] addr_q;
  logic              ack_q, flt_q;

  assign sel      = reg_sel_e'(reg_sel);
  assign grant    = xfer_req & en_q & (count_q != '0) & ~irq7 & ~reg_wr;
  assign step     = grant & ~fault;
  assign cnt_clr  = reg_wr & (sel == SEL_COUNT);

  dmar_cfg #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (reg_wr),
    .sel      (sel),
    .cpu_addr (cpu_addr),
    .wr_data  (wr_data),
    .step     (step),
    .count_q  (count_q),
    .en_q     (en_q),
    .rd_dir_q (rd_dir_q),
    .addr_q   (addr_q)
  );

  dmar_pgchk u_pgchk (
    .grant     (grant),
    .pbits_in  (page_bits_in),
    .rd_dir    (rd_dir_q),
    .fault     (fault),
    .pg_we     (page_wr_en),
    .pbits_new (page_bits_out)
  );

  dmar_fstat #(.ADDR_W(ADDR_W)) u_fstat (
    .clk      (clk),
    .rst_n    (rst_n),
    .flt      (fault),
    .clr      (cnt_clr),
    .rd_dir   (rd_dir_q),
    .pie      (par_irq_en),
    .flt_addr (addr_q),
    .gen_stat (gen_stat),
    .bsr0     (bsr0),
    .bsr1     (bsr1),
    .irq_q    (irq7)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ack_q <= 1'b0;
      flt_q <= 1'b0;
    end else begin
      ack_q <= step;
      flt_q <= fault;
    end
  end

  assign xfer_ack   = ack_q;
  assign xfer_fault = flt_q;
  assign mem_addr   = addr_q;
  assign page_idx   = addr_q[ADDR_W-1:PAGE_SHIFT];
  assign rd_count   = {{(16-CNT_W){1'b1}}, count_q};

  a_r7_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    !(xfer_ack && xfer_fault));

  a_r9_ack_counts: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> (rd_count[CNT_W-1:0] == $past(rd_count[CNT_W-1:0]) - CNT_W'(1)));

  a_r9_ack_advances: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_ack |-> (mem_addr == $past(mem_addr) + ADDR_W'(2)));

  a_r9_wb_mapped: assert property (@(posedge clk) disable iff (!rst_n)
    page_wr_en |-> (page_bits_in != 2'b00 && page_bits_out[1]));

  a_r8_fault_irq: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fault |-> (irq7 && $stable(mem_addr) && $stable(rd_count)));

  a_r11_write_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !page_wr_en);

  a_r11_write_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |=> !xfer_ack && !xfer_fault);

endmodule

// File: tb/test_dma_page_ctl.sv
`timescale 1ns/1ps
module test_dma_page_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic [14:1] cpu_addr = '0;
  logic [15:0] wr_data = '0;
  logic        xfer_req = 1'b0;
  logic        par_irq_en = 1'b0;
  logic [1:0]  page_bits_in;
  logic [15:0] rd_count, gen_stat, bsr0, bsr1;
  logic [21:0] mem_addr;
  logic [9:0]  page_idx;
  logic        xfer_ack, xfer_fault, page_wr_en, irq7;
  logic [1:0]  page_bits_out;

  int    tests = 0;
  int    fails = 0;
  string phase = "R1";

  always #2.5 clk = ~clk;

  logic [1:0] ptab [0:15];
  assign page_bits_in = ptab[page_idx[3:0]];
  always @(posedge clk) if (page_wr_en) ptab[page_idx[3:0]] <= page_bits_out;

  dma_page_ctl i_dma_page_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .cpu_addr(cpu_addr), .wr_data(wr_data), .rd_count(rd_count),
    .mem_addr(mem_addr), .xfer_req(xfer_req), .xfer_ack(xfer_ack),
    .xfer_fault(xfer_fault), .page_idx(page_idx), .page_bits_in(page_bits_in),
    .page_wr_en(page_wr_en), .page_bits_out(page_bits_out),
    .par_irq_en(par_irq_en), .gen_stat(gen_stat), .bsr0(bsr0), .bsr1(bsr1),
    .irq7(irq7)
  );

  // behavioural reference model
  int          m_cnt, m_addr;
  bit          m_en, m_dir, m_irq, m_ack, m_flt;
  logic [15:0] m_gs, m_b0, m_b1;

  function automatic bit m_grant();
    return xfer_req && m_en && m_cnt != 0 && !m_irq && !reg_wr;
  endfunction

  function automatic logic [1:0] m_pbits();
    return ptab[(m_addr >> 12) & 15];
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_addr = 0; m_en = 0; m_dir = 0; m_irq = 0; m_ack = 0; m_flt = 0;
      m_gs = 16'hFFFF; m_b0 = 16'hFFFF; m_b1 = 16'hFFFF;
    end else begin
      bit g;
      logic [1:0] ps;
      g  = m_grant();
      ps = m_pbits();
      m_ack = g && ps != 2'b00;
      m_flt = g && ps == 2'b00;
      if (m_flt) begin
        m_irq = 1;
        m_gs  = 16'hABFF | (m_dir ? 16'h4000 : 16'h0) | (par_irq_en ? 16'h0400 : 16'h0);
        m_b0  = 16'h3C00 | 16'((m_addr >> 16) & 'hFF);
        m_b1  = 16'(m_addr & 'hFFFF);
      end
      if (m_ack) begin
        m_cnt  = m_cnt - 1;
        m_addr = m_addr + 2;
      end
      if (reg_wr) begin
        case (reg_sel)
          2'd0: begin
            m_cnt = ((int'(wr_data) & 'h3FFF) + 1) & 'h3FFF;
            m_dir = wr_data[14];
            m_en  = wr_data[15];
            m_irq = 0;
          end
          2'd1: begin
            if (cpu_addr[14]) m_addr = (m_addr & 'h1FE) | (int'(cpu_addr[13:1]) << 9);
            else              m_addr = (m_addr & 'h3FFE00) | (int'(cpu_addr[8:1]) << 1);
          end
          2'd2: m_dir = wr_data[14];
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", phase, what, act, exp);
    end
  endtask

  task automatic check_regs();
    chk("mem_addr",   32'(mem_addr),   32'(m_addr));
    chk("rd_count",   32'(rd_count),   32'(16'hC000 | 16'(m_cnt)));
    chk("xfer_ack",   32'(xfer_ack),   32'(m_ack));
    chk("xfer_fault", 32'(xfer_fault), 32'(m_flt));
    chk("irq7",       32'(irq7),       32'(m_irq));
    chk("gen_stat",   32'(gen_stat),   32'(m_gs));
    chk("bsr0",       32'(bsr0),       32'(m_b0));
    chk("bsr1",       32'(bsr1),       32'(m_b1));
  endtask

  task automatic check_comb();
    bit pw;
    logic [1:0] ps;
    ps = m_pbits();
    pw = m_grant() && ps != 2'b00;
    chk("page_idx",   32'(page_idx),   32'(m_addr >> 12));
    chk("page_wr_en", 32'(page_wr_en), 32'(pw));
    if (pw)
      chk("page_bits_out", 32'(page_bits_out),
          32'({1'b1, (ps == 2'b11) || (!m_dir && ps[1] != ps[0])}));
  endtask

  task automatic step(input bit wr, input logic [1:0] sel, input logic [15:0] a,
                      input logic [15:0] d, input bit req);
    @(negedge clk);
    check_regs();
    reg_wr   = wr;
    reg_sel  = sel;
    cpu_addr = a[14:1];
    wr_data  = d;
    xfer_req = req;
    #1;
    check_comb();
  endtask

  task automatic idle(input bit req);
    step(1'b0, 2'd3, 16'h0, 16'h0, req);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) ptab[i] = 2'b11;
    ptab[1] = 2'b00;
    ptab[2] = 2'b10;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset values at the ports
    phase = "R1";
    chk("rd_count", 32'(rd_count), 32'h0000C000);
    chk("gen_stat", 32'(gen_stat), 32'h0000FFFF);
    chk("bsr0",     32'(bsr0),     32'h0000FFFF);
    chk("irq7",     32'(irq7),     32'h0);
    chk("mem_addr", 32'(mem_addr), 32'h0);

    phase = "R7";  idle(1); idle(1);                       // disabled: ignored
    phase = "R2";  step(1, 2'd0, 16'h0, 16'h8003, 0); idle(0);
    phase = "R3";  idle(0);
    phase = "R4";  step(1, 2'd1, 16'h400A, 16'hFFFF, 0); idle(0); // addr 0xA00
    phase = "R5";  step(1, 2'd1, 16'h0020, 16'h0, 0); idle(0);   // addr 0xA20
                   step(1, 2'd1, 16'h3E20, 16'h0, 0); idle(0);   // high bits ignored
    ptab[0] = 2'b01;
    phase = "R9";  repeat (4) idle(1);
    phase = "R7";  idle(1); idle(1); idle(0);               // counter empty
    phase = "R2";  step(1, 2'd0, 16'h0, 16'h8002, 0);
    phase = "R4";  step(1, 2'd1, 16'h4020, 16'h0, 0);       // page 2
    phase = "R5";  step(1, 2'd1, 16'h0000, 16'h0, 0);
    phase = "R6";  step(1, 2'd2, 16'h0, 16'h4000, 0);       // direction read
    phase = "R9";  idle(1); idle(0);                        // 10 stays 10
    phase = "R6";  step(1, 2'd2, 16'h0, 16'h0000, 0);       // direction write
    phase = "R9";  idle(1); idle(0);                        // 10 becomes 11
    phase = "R2";  step(1, 2'd0, 16'h0, 16'h8005, 0);
    phase = "R4";  step(1, 2'd1, 16'h4010, 16'h0, 0);       // page 1 unmapped
    phase = "R5";  step(1, 2'd1, 16'h0006, 16'h0, 0);
    par_irq_en = 1'b1;
    phase = "R8";  idle(1); idle(1); idle(1);
    phase = "R10"; idle(1); idle(0);
    par_irq_en = 1'b0;
    step(1, 2'd0, 16'h0, 16'hC005, 0);                      // re-arm, direction read
    phase = "R8";  idle(1); idle(1); idle(0);
    phase = "R10"; step(1, 2'd0, 16'h0, 16'h8003, 0);
    ptab[1] = 2'b01;
    idle(1); idle(0);
    phase = "R11"; step(1, 2'd2, 16'h0, 16'h0000, 1);       // write with request
                   step(1, 2'd0, 16'h0, 16'h8004, 1);
                   idle(1); idle(0);
    phase = "R2";  step(1, 2'd0, 16'h0, 16'h3FFF, 0);       // wraps to 0
    phase = "R7";  idle(1); idle(0);
    @(negedge clk);
    check_regs();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #20000;
    fails++;
    tests++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule